// File: doc/BRIEF.md
# Strobed Parallel Input Capture Buffer

The block records a stream of parallel input words into an internal circular memory. An external device sets each word on the data lines and paces the transfer with a strobe, which runs independently of the system clock. The block brings the strobe into the system clock domain and detects its active edge there. On that edge it samples one data word, trims it to the selected width and writes it to memory.

Software sets the word width, the number of words to take, the strobe polarity and an enable bit, and then issues a start command. While a capture runs, a start/stop status line is held high so that the sender can see the transfer is open. The line drops when the programmed number of words has been taken, or at once on a stop command. A count of zero means the capture never ends by itself and runs until it is stopped.

The second handshake line has no role in this mode, and its output enable stays low. The host watches the fill level and pulls words out through a simple read port. If the memory fills during a capture, further words are dropped and a sticky overflow flag is raised.

Top module: `strobe_capture_buf`

## Requirements
- R1: After reset, `ss_out`, `overflow` and `rd_valid` are 0 and `fill_level` is 0.
- R2: A `cmd_start` pulse while idle with `cfg_enable`=1 raises `ss_out` on the next clock. A start with `cfg_enable`=0 leaves `ss_out` low.
- R3: While `ss_out` is high, each active strobe edge stores exactly one word. Words are read back in arrival order. With `cfg_edge_fall`=0 the active edge is rising.
- R4: With `cfg_edge_fall`=1 only falling strobe edges store words. One full strobe pulse then stores a single word.
- R5: `cfg_width` is latched at start and selects the stored bits: 0 keeps bits [7:0], 1 keeps bits [15:0], 2 or 3 keeps all DATA_W bits. The unselected upper bits are stored as 0.
- R6: With a nonzero `cfg_count` N, exactly N words are stored. `ss_out` falls after the Nth word, and later strobes store nothing.
- R7: With `cfg_count`=0, capture continues until `cmd_stop`. The stop drops `ss_out` on the next clock, later strobes store nothing, and the words already stored stay readable.
- R8: A word that arrives while the memory holds DEPTH words is dropped and sets `overflow`. `overflow` stays set until the next accepted start clears it.
- R9: The second handshake line is released: `hs_oe` and `hs_out` are always 0.
- R10: A `cmd_start` during an active capture is ignored. The word count does not restart.
- R11: A `rd_en` pulse while `fill_level`>0 presents the oldest word on `rd_data` with `rd_valid`=1 on the next clock and lowers `fill_level` by one. A `rd_en` pulse on an empty memory gives no `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (at least 100 MHz) |
| rst | input | 1 | Synchronous active-high reset |
| strobe_in | input | 1 | External strobe, asynchronous to clk |
| data_in | input | DATA_W | Parallel input word |
| cfg_enable | input | 1 | Capture enable; start is refused when 0 |
| cfg_width | input | 2 | Word width select (0 byte, 1 half, 2/3 full) |
| cfg_count | input | CNT_W | Words to capture; 0 means unlimited |
| cfg_edge_fall | input | 1 | 1 selects the falling strobe edge |
| cmd_start | input | 1 | Start pulse |
| cmd_stop | input | 1 | Stop pulse |
| rd_en | input | 1 | Read one stored word |
| rd_data | output | DATA_W | Word read from memory |
| rd_valid | output | 1 | rd_data holds a fresh word |
| fill_level | output | ADDR_W+1 | Number of stored words |
| overflow | output | 1 | Sticky flag: a word was dropped on a full memory |
| ss_out | output | 1 | Start/stop status line, high while capturing |
| hs_out | output | 1 | Second handshake data, held 0 |
| hs_oe | output | 1 | Second handshake output enable, held 0 |

## Verification
Several rules are checked by assertions on every cycle. The status line may rise only after an accepted start, and may never rise after a refused start. A stop ends a running capture. Writes happen only inside an active capture. The fill level never exceeds the depth, and a write to a full memory leaves it full with the overflow flag set. A read strobe is followed only by a valid word. The scenarios are needed for the rest: data order and content after the width mask, the choice of strobe polarity, the exact word count for a limited capture, and the ignored restart. They also show that stored words survive a stop, and that the overflow flag clears on the next start.

// File: rtl/scb_pkg.sv
package scb_pkg;
  typedef enum logic [1:0] {
    W_BYTE = 2'd0,
    W_HALF = 2'd1,
    W_FULL = 2'd2,
    W_FULL2 = 2'd3
  } width_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } cap_state_e;
endpackage

// File: rtl/scb_strobe_sync.sv
module scb_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic strobe_in,
  input  logic edge_fall,
  output logic edge_hit
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  // Synchronizer chain: stage 0 samples the pin, the later stages settle it.
  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[0] <= 1'b0;
          else     sync_q[0] <= strobe_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[g] <= 1'b0;
          else     sync_q[g] <= sync_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) last_q <= 1'b0;
    else     last_q <= sync_q[STAGES-1];
  end

  // Both samples go through the same polarity flip, so a change of polarity
  // does not create a false edge.
  logic cur_n, prev_n;
  assign cur_n    = sync_q[STAGES-1] ^ edge_fall;
  assign prev_n   = last_q ^ edge_fall;
  assign edge_hit = cur_n & ~prev_n;
endmodule

// File: rtl/scb_capture_ctrl.sv
module scb_capture_ctrl
  import scb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              edge_hit,
  input  logic [DATA_W-1:0] data_in,
  input  logic              cfg_enable,
  input  logic [1:0]        cfg_width,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  output logic              start_ok,
  output logic              wr_req,
  output logic [DATA_W-1:0] wr_data,
  output logic              ss_out
);
  localparam logic [DATA_W-1:0] MASK_B = DATA_W'({8{1'b1}});
  localparam logic [DATA_W-1:0] MASK_H = DATA_W'({16{1'b1}});
  localparam logic [DATA_W-1:0] MASK_F = {DATA_W{1'b1}};

  cap_state_e       state_q;
  width_e           width_q;
  logic [CNT_W-1:0] limit_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DATA_W-1:0] mask_w;
  logic             last_word;

  assign start_ok = cmd_start && cfg_enable && (state_q == ST_IDLE);
  assign ss_out   = (state_q == ST_RUN);

  always_comb begin
    unique case (width_q)
      W_BYTE:  mask_w = MASK_B;
      W_HALF:  mask_w = MASK_H;
      default: mask_w = MASK_F;
    endcase
  end

  assign last_word = (limit_q != '0) && (cnt_q == limit_q - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      width_q <= W_FULL;
      limit_q <= '0;
      cnt_q   <= '0;
      wr_req  <= 1'b0;
      wr_data <= '0;
    end else begin
      wr_req <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_ok) begin
            state_q <= ST_RUN;
            width_q <= width_e'(cfg_width);
            limit_q <= cfg_count;
            cnt_q   <= '0;
          end
        end
        ST_RUN: begin
          if (cmd_stop) begin
            state_q <= ST_IDLE;
          end else if (edge_hit) begin
            wr_req  <= 1'b1;
            wr_data <= data_in & mask_w;
            cnt_q   <= cnt_q + 1'b1;
            if (last_word) state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/scb_ring_mem.sv
module scb_ring_mem #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1024,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_ovf,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [ADDR_W:0]   fill,
  output logic              overflow
);
  localparam logic [ADDR_W:0]   FULL_LVL = (ADDR_W+1)'(DEPTH);
  localparam logic [ADDR_W-1:0] LAST_PTR = ADDR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wptr_q, rptr_q;
  logic              full_w, empty_w, wr_ok, rd_ok;

  assign full_w  = (fill == FULL_LVL);
  assign empty_w = (fill == '0);
  assign wr_ok   = wr_en && !full_w;
  assign rd_ok   = rd_en && !empty_w;

  // Storage without reset, registered read: maps onto block RAM.
  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr_q] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rd_ok) rd_data <= mem[rptr_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q   <= '0;
      rptr_q   <= '0;
      fill     <= '0;
      rd_valid <= 1'b0;
      overflow <= 1'b0;
    end else begin
      rd_valid <= rd_ok;
      if (wr_ok) wptr_q <= (wptr_q == LAST_PTR) ? '0 : wptr_q + 1'b1;
      if (rd_ok) rptr_q <= (rptr_q == LAST_PTR) ? '0 : rptr_q + 1'b1;
      unique case ({wr_ok, rd_ok})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
      if (clr_ovf)                overflow <= 1'b0;
      else if (wr_en && full_w)   overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/strobe_capture_buf.sv
module strobe_capture_buf #(
  parameter int DATA_W      = 32,
  parameter int DEPTH       = 1024,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic              cfg_enable,
  input  logic [1:0]        cfg_width,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic              cfg_edge_fall,
  input  logic              cmd_start,
  input  logic              cmd_stop,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic [ADDR_W:0]   fill_level,
  output logic              overflow,
  output logic              ss_out,
  output logic              hs_out,
  output logic              hs_oe
);
  logic              edge_hit;
  logic              start_ok;
  logic              wr_req;
  logic [DATA_W-1:0] wr_data;

  assign hs_out = 1'b0;
  assign hs_oe  = 1'b0;

  scb_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .strobe_in (strobe_in),
    .edge_fall (cfg_edge_fall),
    .edge_hit  (edge_hit)
  );

  scb_capture_ctrl #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .edge_hit   (edge_hit),
    .data_in    (data_in),
    .cfg_enable (cfg_enable),
    .cfg_width  (cfg_width),
    .cfg_count  (cfg_count),
    .cmd_start  (cmd_start),
    .cmd_stop   (cmd_stop),
    .start_ok   (start_ok),
    .wr_req     (wr_req),
    .wr_data    (wr_data),
    .ss_out     (ss_out)
  );

  scb_ring_mem #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk      (clk),
    .rst      (rst),
    .clr_ovf  (start_ok),
    .wr_en    (wr_req),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .rd_data  (rd_data),
    .rd_valid (rd_valid),
    .fill     (fill_level),
    .overflow (overflow)
  );
endmodule

// File: rtl/scb_checker.sv
module scb_checker #(
  parameter int DEPTH  = 1024,
  parameter int ADDR_W = 10
) (
  input logic            clk,
  input logic            rst,
  input logic            cmd_start,
  input logic            cmd_stop,
  input logic            cfg_enable,
  input logic            start_ok,
  input logic            wr_req,
  input logic            rd_en,
  input logic            rd_valid,
  input logic            ss_out,
  input logic            overflow,
  input logic [ADDR_W:0] fill_level
);
  localparam logic [ADDR_W:0] FULL_LVL = (ADDR_W+1)'(DEPTH);

  p_start_gate_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(ss_out) |-> $past(start_ok));

  p_refused_start_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_start && !cfg_enable && !ss_out) |=> !ss_out);

  p_write_in_capture_r3: assert property (@(posedge clk) disable iff (rst)
    wr_req |-> $past(ss_out));

  p_stop_ends_r7: assert property (@(posedge clk) disable iff (rst)
    (cmd_stop && ss_out) |=> !ss_out);

  p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_req && fill_level == FULL_LVL && !rd_en && !start_ok)
      |=> (fill_level == FULL_LVL && overflow));

  p_fill_bound_r11: assert property (@(posedge clk) disable iff (rst)
    fill_level <= FULL_LVL);

  p_read_source_r11: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_en && fill_level != '0));
endmodule

bind strobe_capture_buf scb_checker #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_start  (cmd_start),
  .cmd_stop   (cmd_stop),
  .cfg_enable (cfg_enable),
  .start_ok   (start_ok),
  .wr_req     (wr_req),
  .rd_en      (rd_en),
  .rd_valid   (rd_valid),
  .ss_out     (ss_out),
  .overflow   (overflow),
  .fill_level (fill_level)
);

// File: tb/sim_strobe_capture_buf.sv
`timescale 1ns/1ps
module sim_strobe_capture_buf;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 1024;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = $clog2(DEPTH);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              strobe_in = 1'b0;
  logic [DATA_W-1:0] data_in = '0;
  logic              cfg_enable = 1'b0;
  logic [1:0]        cfg_width = 2'd2;
  logic [CNT_W-1:0]  cfg_count = '0;
  logic              cfg_edge_fall = 1'b0;
  logic              cmd_start = 1'b0;
  logic              cmd_stop = 1'b0;
  logic              rd_en = 1'b0;
  logic [DATA_W-1:0] rd_data;
  logic              rd_valid;
  logic [ADDR_W:0]   fill_level;
  logic              overflow, ss_out, hs_out, hs_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [DATA_W-1:0] exp_q[$];
  logic [1:0] run_width = 2'd2;

  always #4 clk = ~clk;

  strobe_capture_buf #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst(rst), .strobe_in(strobe_in), .data_in(data_in),
    .cfg_enable(cfg_enable), .cfg_width(cfg_width), .cfg_count(cfg_count),
    .cfg_edge_fall(cfg_edge_fall), .cmd_start(cmd_start), .cmd_stop(cmd_stop),
    .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .fill_level(fill_level), .overflow(overflow), .ss_out(ss_out),
    .hs_out(hs_out), .hs_oe(hs_oe)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] trim(input logic [DATA_W-1:0] d, input logic [1:0] w);
    case (w)
      2'd0:    return d & 32'h0000_00FF;
      2'd1:    return d & 32'h0000_FFFF;
      default: return d;
    endcase
  endfunction

  // Monitor: compare every word the design hands out against the queue (R3, R5, R11).
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R11 unexpected word", rd_data, 0);
      end else begin
        logic [DATA_W-1:0] e;
        e = exp_q.pop_front();
        chk(rd_data == e, "R3/R5 read data", rd_data, e);
      end
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic start_cap(input logic [CNT_W-1:0] cnt, input logic [1:0] w);
    cfg_count = cnt;
    cfg_width = w;
    @(negedge clk) cmd_start = 1'b1;
    @(negedge clk) cmd_start = 1'b0;
    run_width = w;
  endtask

  task automatic stop_cap();
    @(negedge clk) cmd_stop = 1'b1;
    @(negedge clk) cmd_stop = 1'b0;
  endtask

  // Driver: one strobe pulse, 56 ns per phase; pushes the expected word if stored.
  task automatic send(input logic [DATA_W-1:0] d, input bit store);
    data_in = d;
    if (store) exp_q.push_back(trim(d, run_width));
    cycles(3);
    strobe_in = ~strobe_in;
    cycles(7);
    strobe_in = ~strobe_in;
    cycles(7);
  endtask

  task automatic drain(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) rd_en = 1'b1;
    end
    @(negedge clk) rd_en = 1'b0;
    cycles(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    cycles(5);
    rst = 1'b0;
    cycles(1);
    chk(ss_out == 1'b0, "R1 ss_out", ss_out, 0);
    chk(fill_level == 0, "R1 fill_level", fill_level, 0);
    chk(overflow == 1'b0, "R1 overflow", overflow, 0);
    chk(rd_valid == 1'b0, "R1 rd_valid", rd_valid, 0);
    chk(hs_oe == 1'b0, "R9 hs_oe", hs_oe, 0);
    chk(hs_out == 1'b0, "R9 hs_out", hs_out, 0);

    // R2: start refused while disabled
    cfg_enable = 1'b0;
    start_cap(0, 2'd2);
    cycles(2);
    chk(ss_out == 1'b0, "R2 disabled start", ss_out, 0);
    send(32'hDEAD_0001, 1'b0);
    chk(fill_level == 0, "R2 no capture when refused", fill_level, 0);

    // R3 / R7: continuous capture, rising edge, stop keeps words
    cfg_enable = 1'b1;
    start_cap(0, 2'd2);
    chk(ss_out == 1'b1, "R2 ss_out after start", ss_out, 1);
    send(32'h1111_2222, 1'b1);
    send(32'h3333_4444, 1'b1);
    send(32'h5555_6666, 1'b1);
    chk(fill_level == 3, "R3 one word per edge", fill_level, 3);
    chk(ss_out == 1'b1, "R7 count 0 keeps running", ss_out, 1);
    chk(hs_oe == 1'b0, "R9 hs_oe during capture", hs_oe, 0);
    stop_cap();
    chk(ss_out == 1'b0, "R7 stop drops ss_out", ss_out, 0);
    send(32'h7777_8888, 1'b0);
    chk(fill_level == 3, "R7 strobe after stop ignored", fill_level, 3);
    drain(3);
    chk(fill_level == 0, "R11 fill after drain", fill_level, 0);

    // R11: read on empty memory
    @(negedge clk) rd_en = 1'b1;
    @(negedge clk) rd_en = 1'b0;
    chk(rd_valid == 1'b0, "R11 empty read", rd_valid, 0);

    // R5: width selection
    start_cap(0, 2'd0);
    send(32'hA5C3_F00F, 1'b1);
    send(32'h1234_5678, 1'b1);
    stop_cap();
    start_cap(0, 2'd1);
    send(32'hA5C3_F00F, 1'b1);
    stop_cap();
    start_cap(0, 2'd3);
    send(32'hA5C3_F00F, 1'b1);
    stop_cap();
    chk(fill_level == 4, "R5 width captures stored", fill_level, 4);
    drain(4);

    // R4: falling-edge polarity; strobe idles high
    cfg_edge_fall = 1'b1;
    strobe_in = 1'b1;
    cycles(6);
    start_cap(0, 2'd2);
    send(32'hCAFE_0001, 1'b1);
    send(32'hCAFE_0002, 1'b1);
    stop_cap();
    chk(fill_level == 2, "R4 one word per falling edge", fill_level, 2);
    drain(2);
    strobe_in = 1'b0;
    cycles(6);
    cfg_edge_fall = 1'b0;
    cycles(2);

    // R6: limited count
    start_cap(3, 2'd2);
    send(32'h0000_00A1, 1'b1);
    send(32'h0000_00A2, 1'b1);
    chk(ss_out == 1'b1, "R6 running before last", ss_out, 1);
    send(32'h0000_00A3, 1'b1);
    chk(ss_out == 1'b0, "R6 ss_out falls after N", ss_out, 0);
    send(32'h0000_00A4, 1'b0);
    send(32'h0000_00A5, 1'b0);
    chk(fill_level == 3, "R6 exactly N stored", fill_level, 3);
    drain(3);

    // R10: restart during capture ignored
    start_cap(3, 2'd2);
    send(32'h0000_00B1, 1'b1);
    send(32'h0000_00B2, 1'b1);
    start_cap(3, 2'd2);
    send(32'h0000_00B3, 1'b1);
    chk(ss_out == 1'b0, "R10 count not restarted", ss_out, 0);
    chk(fill_level == 3, "R10 fill", fill_level, 3);
    drain(3);

    // R8: overflow on full memory
    start_cap(0, 2'd2);
    for (int i = 0; i < DEPTH + 2; i++) send(32'h0100_0000 + i, i < DEPTH);
    chk(overflow == 1'b1, "R8 overflow set", overflow, 1);
    chk(fill_level == DEPTH, "R8 fill stays at depth", fill_level, DEPTH);
    stop_cap();
    chk(overflow == 1'b1, "R8 overflow sticky after stop", overflow, 1);
    drain(DEPTH);
    start_cap(0, 2'd2);
    chk(overflow == 1'b0, "R8 overflow cleared by start", overflow, 0);
    stop_cap();

    chk(exp_q.size() == 0, "R3 all expected words read", exp_q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule